// File: doc/BRIEF.md
# Dual-Stream OFDM Delay Correlator

This block performs coarse time synchronization for two OFDM receive streams at once. For every accepted sample of a stream it multiplies the current complex sample by the complex conjugate of the sample received a configurable number of samples earlier. That number is one useful-symbol length. It then keeps a running sum of these products over a configurable window, one cyclic-prefix length long. The summed complex value is the correlation metric. A downstream stage looks for its magnitude peak to find symbol timing, and reads its phase to estimate the fractional frequency offset. This block does not do the peak search or the phase calculation.

Inputs are 4-bit signed real and imaginary parts. All arithmetic runs in two 16-bit lanes, one for the in-phase result and one for the quadrature result, evaluated side by side. Each stream has its own lag, window length and sign-only mode, so the two streams may follow different radio standards or transmission modes. A configuration is loaded at run time through a shared configuration bus and a per-stream load strobe. Loading also flushes that stream's history. Both the sample history and the product history are sized at build time for the longest mode needed, and a shorter length is chosen per stream when a configuration is loaded.

Top module: `ofdm_dual_xcorr`

## Requirements
- R1: After reset both streams have lag MAX_DELAY, window MAX_WIN and sign-only mode off, `out_valid` is 0 and every output lane is 0.
- R2: For an accepted sample x[n] = a + jb of stream k, with lag D, the product is p[n] = x[n]·conj(x[n−D]). Its real part is a·c + b·d and its imaginary part is b·c − a·d, where x[n−D] = c + jd. Sample indices count only accepted samples since the last flush.
- R3: `out_valid[k]` is 1 in the cycle after an accepted sample with index n ≥ D+W−1, where W is the window length. In that cycle `out_re`/`out_im` of stream k equal the sum of p[n−W+1..n]. Otherwise `out_valid[k]` is 0.
- R4: Each lane sum is kept in a 16-bit accumulator that wraps modulo 2^16.
- R5: A 1 on `cfg_load[k]` loads `cfg_delay`, `cfg_win` and `cfg_sign` into stream k and discards its history. A sample offered to stream k in that same cycle is dropped. In the next cycle stream k shows both lanes at 0 and `out_valid[k]` at 0, and sample indexing restarts at 0.
- R6: The two streams are independent. Samples, loads and configuration of one stream do not change the outputs of the other.
- R7: In sign-only mode every real and imaginary input part is replaced before any use: by +1 when its bit 3 is 0, and by −1 when its bit 3 is 1.
- R8: A cycle with `in_valid[k]` at 0 and no load leaves stream k's sums unchanged and gives `out_valid[k]` 0 in the next cycle.
- R9: A loaded lag of 0 is used as 1, and a lag above MAX_DELAY is used as MAX_DELAY. A loaded window of 0 is used as 1, and a window above MAX_WIN is used as MAX_WIN.
- R10: Stream k uses input bits [4k+3:4k] of `in_re`/`in_im` and output bits [16k+15:16k] of `out_re`/`out_im`. All values are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 2 | Per-stream load-and-flush strobe |
| cfg_delay | input | $clog2(MAX_DELAY+1) | Lag (useful-symbol length) to load |
| cfg_win | input | $clog2(MAX_WIN+1) | Window (cyclic-prefix length) to load |
| cfg_sign | input | 1 | Sign-only mode to load |
| in_valid | input | 2 | Per-stream sample strobe |
| in_re | input | 8 | Real parts, 4 bits per stream |
| in_im | input | 8 | Imaginary parts, 4 bits per stream |
| out_valid | output | 2 | Per-stream metric valid pulse |
| out_re | output | 32 | Real lane of the metric, 16 bits per stream |
| out_im | output | 32 | Imaginary lane of the metric, 16 bits per stream |

## Verification
The bench first runs with the reset lengths and feeds constant full-scale negative samples until the first valid output. A design that failed to wrap at 16 bits, or that came out of reset with the wrong lengths, would give the first pulse in the wrong cycle or with the wrong value. It then loads one stream while that stream is offering a sample. A design that kept the sample, or that left old sums or old history in place, would show a nonzero lane or an early pulse, and the other stream would be disturbed. A sign-only stream checks that the delayed copy is also reduced to ±1, not only the current sample. Lag and window values of zero and above the maximum check the clamping, which would otherwise index past the storage or never fill the window.

// File: rtl/xcorr_pkg.sv
// Shared constants and types for the dual-stream delay correlator.
// Assumes two's complement samples and 16-bit arithmetic lanes.
package xcorr_pkg;
    localparam int SAMP_W  = 4;
    localparam int LANE_W  = 16;
    localparam int NSTREAM = 2;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [LANE_W-1:0] lane_t;

    typedef struct packed {
        samp_t re;
        samp_t im;
    } csamp_t;

    typedef struct packed {
        lane_t re;
        lane_t im;
    } clane_t;
endpackage

// File: rtl/xc_delay_line.sv
// Circular history buffer with a run-time length (1..DEPTH).
// dout presents the entry pushed `len` pushes ago, valid once level == len.
// Assumes len changes only together with flush and is never 0.
module xc_delay_line #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [LEN_W-1:0] len,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [LEN_W-1:0] level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] ptr;
    logic [LEN_W-1:0] cnt;
    logic             at_end;

    assign at_end = (LEN_W'(ptr) == len - LEN_W'(1));
    assign dout   = mem[ptr];
    assign level  = cnt;

    // Storage write: oldest slot is overwritten by the newest entry.
    always_ff @(posedge clk) begin
        if (push) mem[ptr] <= din;
    end

    // Pointer wraps at the run-time length; level saturates at len.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr <= '0;
            cnt <= '0;
        end else if (push) begin
            ptr <= at_end ? '0 : ptr + PTR_W'(1);
            if (cnt != len) cnt <= cnt + LEN_W'(1);
        end
    end

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= len);

    // R9
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        LEN_W'(ptr) < len);
endmodule

// File: rtl/xc_conj_mult.sv
// Complex product of a sample with the conjugate of a lagged sample,
// with both results in 16-bit lanes computed side by side. Purely combinational.
module xc_conj_mult
    import xcorr_pkg::*;
(
    input  csamp_t cur,
    input  csamp_t lagged,
    output clane_t prod
);
    lane_t a, b, c, d;

    // Sign-extend the four parts into lane width.
    always_comb begin
        a = lane_t'(cur.re);
        b = lane_t'(cur.im);
        c = lane_t'(lagged.re);
        d = lane_t'(lagged.im);
    end

    // In-phase and quadrature lanes evaluated in parallel.
    always_comb begin
        prod.re = a * c + b * d;
        prod.im = b * c - a * d;
    end
endmodule

// File: rtl/xc_stream.sv
// One correlation stream: configuration registers, optional sign reduction,
// lag buffer, conjugate product, product window and running sum.
// Assumes cfg_load both loads the configuration and flushes all history.
module xc_stream
    import xcorr_pkg::*;
#(
    parameter int MAX_DELAY = 256,
    parameter int MAX_WIN   = 256,
    localparam int DLY_W = $clog2(MAX_DELAY + 1),
    localparam int WIN_W = $clog2(MAX_WIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [WIN_W-1:0] cfg_win,
    input  logic             cfg_sign,
    input  logic             in_valid,
    input  csamp_t           in_samp,
    output logic             out_valid,
    output clane_t           out_corr
);
    logic [DLY_W-1:0] dly_len, dly_level;
    logic [WIN_W-1:0] win_len, win_level;
    logic             sign_mode;
    logic             flush, push, push_w;
    logic             dly_full, win_full, win_last;
    csamp_t           cond, lagged;
    clane_t           prod, oldest, acc;

    assign flush = cfg_load;
    assign push  = in_valid && !cfg_load;

    // Load clamped lengths and mode; reset selects the longest mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_len   <= DLY_W'(MAX_DELAY);
            win_len   <= WIN_W'(MAX_WIN);
            sign_mode <= 1'b0;
        end else if (cfg_load) begin
            if (cfg_delay == '0)                   dly_len <= DLY_W'(1);
            else if (cfg_delay > DLY_W'(MAX_DELAY)) dly_len <= DLY_W'(MAX_DELAY);
            else                                    dly_len <= cfg_delay;
            if (cfg_win == '0)                     win_len <= WIN_W'(1);
            else if (cfg_win > WIN_W'(MAX_WIN))    win_len <= WIN_W'(MAX_WIN);
            else                                    win_len <= cfg_win;
            sign_mode <= cfg_sign;
        end
    end

    // Sign-only mode maps each part to +1 or -1 before storage and use.
    always_comb begin
        cond = in_samp;
        if (sign_mode) begin
            cond.re = in_samp.re[SAMP_W-1] ? -samp_t'(1) : samp_t'(1);
            cond.im = in_samp.im[SAMP_W-1] ? -samp_t'(1) : samp_t'(1);
        end
    end

    xc_delay_line #(.WIDTH($bits(csamp_t)), .DEPTH(MAX_DELAY)) u_lag (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
        .len(dly_len), .din(cond), .dout(lagged), .level(dly_level)
    );

    xc_conj_mult u_mult (.cur(cond), .lagged(lagged), .prod(prod));

    assign dly_full = (dly_level == dly_len);
    assign push_w   = push && dly_full;

    xc_delay_line #(.WIDTH($bits(clane_t)), .DEPTH(MAX_WIN)) u_win (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push_w),
        .len(win_len), .din(prod), .dout(oldest), .level(win_level)
    );

    assign win_full = (win_level == win_len);
    assign win_last = (win_level == win_len - WIN_W'(1));

    // Running sum: add newest product, drop the one leaving the window.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            acc       <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= push_w && (win_full || win_last);
            if (push_w) begin
                acc.re <= acc.re + prod.re - (win_full ? oldest.re : lane_t'(0));
                acc.im <= acc.im + prod.im - (win_full ? oldest.im : lane_t'(0));
            end
        end
    end

    assign out_corr = acc;

    // R5
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (out_corr == '0 && !out_valid));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !flush) |=> ($stable(out_corr) && !out_valid));

    // R7
    sign_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sign_mode && push) |-> ((cond.re == 4'sd1 || cond.re == -4'sd1) &&
                                 (cond.im == 4'sd1 || cond.im == -4'sd1)));
endmodule

// File: rtl/ofdm_dual_xcorr.sv
// Top level: two independent delay-correlation streams that share one
// configuration bus and have separate load strobes and sample ports.
// Assumes synchronous active-low reset and 4-bit two's complement inputs.
module ofdm_dual_xcorr
    import xcorr_pkg::*;
#(
    parameter int MAX_DELAY = 256,
    parameter int MAX_WIN   = 256,
    localparam int DLY_W = $clog2(MAX_DELAY + 1),
    localparam int WIN_W = $clog2(MAX_WIN + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSTREAM-1:0]         cfg_load,
    input  logic [DLY_W-1:0]           cfg_delay,
    input  logic [WIN_W-1:0]           cfg_win,
    input  logic                       cfg_sign,
    input  logic [NSTREAM-1:0]         in_valid,
    input  logic [NSTREAM*SAMP_W-1:0]  in_re,
    input  logic [NSTREAM*SAMP_W-1:0]  in_im,
    output logic [NSTREAM-1:0]         out_valid,
    output logic [NSTREAM*LANE_W-1:0]  out_re,
    output logic [NSTREAM*LANE_W-1:0]  out_im
);
    for (genvar k = 0; k < NSTREAM; k++) begin : g_stream
        csamp_t samp;
        clane_t corr;

        assign samp.re = in_re[k*SAMP_W +: SAMP_W];
        assign samp.im = in_im[k*SAMP_W +: SAMP_W];

        xc_stream #(.MAX_DELAY(MAX_DELAY), .MAX_WIN(MAX_WIN)) u_stream (
            .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load[k]),
            .cfg_delay(cfg_delay), .cfg_win(cfg_win), .cfg_sign(cfg_sign),
            .in_valid(in_valid[k]), .in_samp(samp),
            .out_valid(out_valid[k]), .out_corr(corr)
        );

        assign out_re[k*LANE_W +: LANE_W] = corr.re;
        assign out_im[k*LANE_W +: LANE_W] = corr.im;

        // R6
        own_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k] |-> $past(in_valid[k] && !cfg_load[k]));
    end
endmodule

// File: tb/ofdm_dual_xcorr_bench.sv
module ofdm_dual_xcorr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MD = 32;
    localparam int MW = 300;
    localparam int DW = $clog2(MD + 1);
    localparam int WW = $clog2(MW + 1);
    localparam int HIST = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_load = '0;
    logic [DW-1:0] cfg_delay = '0;
    logic [WW-1:0] cfg_win = '0;
    logic          cfg_sign = 1'b0;
    logic [1:0]    in_valid = '0;
    logic [7:0]    in_re = '0, in_im = '0;
    logic [1:0]    out_valid;
    logic [31:0]   out_re, out_im;

    always #(CLK_PERIOD/2) clk = ~clk;

    ofdm_dual_xcorr #(.MAX_DELAY(MD), .MAX_WIN(MW)) u_ofdm_dual_xcorr (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_delay(cfg_delay),
        .cfg_win(cfg_win), .cfg_sign(cfg_sign), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
        .out_re(out_re), .out_im(out_im)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;

    // Reference state, per stream
    int hre [2][HIST];
    int him [2][HIST];
    int cnt [2];
    int md  [2];
    int mwin[2];
    bit msg [2];
    bit expv[2];
    logic [15:0] exr[2], exi[2];

    // Table: {v0, re0, im0, v1, re1, im1}
    localparam logic [17:0] VEC [24] = '{
        {1'b1,4'h3,4'hE, 1'b1,4'h7,4'h8}, {1'b1,4'h1,4'h2, 1'b1,4'h0,4'h3},
        {1'b1,4'h8,4'h7, 1'b1,4'hF,4'h1}, {1'b1,4'h5,4'h5, 1'b0,4'h2,4'h2},
        {1'b0,4'h9,4'h9, 1'b1,4'h8,4'hF}, {1'b1,4'hC,4'h4, 1'b1,4'h4,4'hC},
        {1'b1,4'h7,4'h7, 1'b1,4'h1,4'h9}, {1'b1,4'h8,4'h8, 1'b1,4'hA,4'h6},
        {1'b1,4'h2,4'hD, 1'b0,4'h0,4'h0}, {1'b1,4'hF,4'h0, 1'b1,4'h3,4'h3},
        {1'b0,4'h1,4'h1, 1'b1,4'hE,4'hE}, {1'b1,4'h6,4'hB, 1'b1,4'h5,4'hA},
        {1'b1,4'hA,4'h3, 1'b1,4'h7,4'h7}, {1'b1,4'h4,4'hF, 1'b1,4'h9,4'h2},
        {1'b1,4'h0,4'h6, 1'b1,4'hB,4'h4}, {1'b1,4'hD,4'h1, 1'b1,4'h6,4'hD},
        {1'b1,4'h3,4'h3, 1'b0,4'h1,4'h1}, {1'b1,4'hE,4'hA, 1'b1,4'h2,4'hF},
        {1'b1,4'h7,4'h8, 1'b1,4'hC,4'h0}, {1'b1,4'h9,4'h5, 1'b1,4'h8,4'h8},
        {1'b0,4'h0,4'h0, 1'b1,4'h4,4'h5}, {1'b1,4'hB,4'hC, 1'b1,4'hF,4'hF},
        {1'b1,4'h2,4'h7, 1'b1,4'h0,4'h8}, {1'b1,4'h8,4'h1, 1'b1,4'h7,4'h3}
    };

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int clampv(input int v, input int mx);
        return (v == 0) ? 1 : ((v > mx) ? mx : v);
    endfunction

    function automatic int s4(input logic [3:0] v, input bit sg);
        if (sg) return v[3] ? -1 : 1;
        return int'($signed(v));
    endfunction

    // Model one stream for one clock edge (R2 R3 R4 R5 R7 R9)
    task automatic model(input int k, input bit ld, input bit v,
                         input logic [3:0] r, input logic [3:0] i);
        expv[k] = 0;
        if (ld) begin
            md[k]   = clampv(int'(cfg_delay), MD);
            mwin[k] = clampv(int'(cfg_win), MW);
            msg[k]  = cfg_sign;
            cnt[k]  = 0;
        end else if (v) begin
            int n = cnt[k];
            hre[k][n] = s4(r, msg[k]);
            him[k][n] = s4(i, msg[k]);
            if (n >= md[k] + mwin[k] - 1) begin
                int sr = 0, si = 0;
                for (int m = n - mwin[k] + 1; m <= n; m++) begin
                    int a = hre[k][m], b = him[k][m];
                    int c = hre[k][m-md[k]], d = him[k][m-md[k]];
                    sr += a*c + b*d;
                    si += b*c - a*d;
                end
                expv[k] = 1;
                exr[k] = 16'(sr);
                exi[k] = 16'(si);
            end
            cnt[k] = n + 1;
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic [1:0] ld, input logic [17:0] v, input string tag);
        cfg_load = ld;
        in_valid = {v[8], v[17]};
        in_re    = {v[7:4], v[16:13]};
        in_im    = {v[3:0], v[12:9]};
        @(posedge clk);
        model(0, ld[0], v[17], v[16:13], v[12:9]);
        model(1, ld[1], v[8], v[7:4], v[3:0]);
        @(negedge clk);
        cfg_load = '0;
        in_valid = '0;
        for (int k = 0; k < 2; k++) begin
            logic [15:0] ar = out_re[16*k +: 16];
            logic [15:0] ai = out_im[16*k +: 16];
            chk(out_valid[k] == expv[k], {tag, " valid"}, 16'(out_valid[k]), 16'(expv[k]));
            if (expv[k]) begin
                chk(ar == exr[k], {tag, " re"}, ar, exr[k]);
                chk(ai == exi[k], {tag, " im"}, ai, exi[k]);
            end
            if (ld[k]) begin
                chk(ar == 16'h0 && ai == 16'h0, "R5 flush clears lanes", ar | ai, 16'h0);
            end
        end
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            cnt[k] = 0; md[k] = MD; mwin[k] = MW; msg[k] = 0; expv[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 2'b00, "R1 valid after reset", 16'(out_valid), 16'h0);
        chk(out_re == 32'h0 && out_im == 32'h0, "R1 lanes after reset",
            out_re[15:0] | out_im[15:0], 16'h0);

        // R1 default lengths, R4 wrap, R8 idle stream 1
        for (int n = 0; n < MD + MW; n++) begin
            step(2'b00, {1'b1,4'h8,4'h8, 1'b0,4'h0,4'h0}, "R1 R4 R8 default");
            if (n == MD + MW - 1) begin
                chk(out_valid[0] && out_re[15:0] == 16'h9600, "R4 wrapped sum",
                    out_re[15:0], 16'h9600);
            end
        end

        // Load stream 0: lag 3, window 4, normal; stream 1: lag 2, window 3, sign-only
        cfg_delay = DW'(3); cfg_win = WW'(4); cfg_sign = 1'b0;
        step(2'b01, '0, "R5 load s0");
        cfg_delay = DW'(2); cfg_win = WW'(3); cfg_sign = 1'b1;
        step(2'b10, '0, "R5 load s1");

        // Table walk: R2 R3 R7 R10 R6
        for (int t = 0; t < 24; t++) step(2'b00, VEC[t], "R2 R3 R7 R10 table");

        // Flush stream 0 while it offers a sample; stream 1 keeps running (R5 R6)
        cfg_delay = DW'(2); cfg_win = WW'(2); cfg_sign = 1'b0;
        step(2'b01, {1'b1,4'h7,4'h7, 1'b1,4'h3,4'h5}, "R5 R6 flush s0");
        for (int t = 0; t < 8; t++) step(2'b00, VEC[t], "R5 R6 after flush");

        // Clamp: stream 1 lag 0 and window 0 become 1 (R9)
        cfg_delay = DW'(0); cfg_win = WW'(0); cfg_sign = 1'b0;
        step(2'b10, '0, "R9 load zero");
        for (int t = 8; t < 16; t++) step(2'b00, VEC[t], "R9 zero lengths");

        // Clamp: stream 0 lag above maximum becomes MD (R9)
        cfg_delay = DW'(63); cfg_win = WW'(2); cfg_sign = 1'b0;
        step(2'b01, '0, "R9 load over");
        for (int t = 0; t < MD + 6; t++)
            step(2'b00, VEC[t % 24] | 18'h20000, "R9 lag clamp");

        // Idle cycles: R8
        for (int t = 0; t < 3; t++) step(2'b00, '0, "R8 idle");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule